// File: doc/BRIEF.md
# PCI Interrupt Router with SCI Merge

This block takes the eight shared PCI interrupt request lines (PIRQ A through H) and presents them to two kinds of interrupt controller at once. On the legacy side each PIRQ can be steered by a programmable routing byte onto one of sixteen PIC inputs. Several PIRQs may share one PIC input; the input is then the OR of them. On the APIC side every PIRQ owns a fixed input, GSI 16 plus its index, and no two PIRQs share it.

A single ACPI system control interrupt (SCI) level is merged on top. A three-bit select register picks the SCI's line, which can be a PIC input or one of the APIC inputs. The SCI level is ORed onto that line, so moving the select while SCI is high releases the old line and raises the new one in the same cycle.

A small write port loads the eight routing bytes and the SCI select. For every PIRQ a route-status output reports where its legacy route currently lands. The PIRQ and SCI inputs are registered once. Every output is a combinational function of those registers and the configuration registers.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte holds 0x80 (legacy route disabled) and the SCI select holds 3'b000. With PIRQ and SCI low, all PIC and APIC outputs are low.
- R2: APIC output n (GSI 16+n) is high one cycle after PIRQ n is sampled high, whatever its routing byte holds.
- R3: PIC output k is the OR of every PIRQ whose routing byte has bit 7 clear and low nibble equal to k. The output follows the inputs one cycle after they are sampled.
- R4: A PIRQ whose routing byte has bit 7 set drives no PIC output.
- R5: SCI select encodings: 3'b000 targets IRQ 9, 3'b001 IRQ 10, 3'b010 IRQ 11, 3'b100 GSI 20 (APIC output 4), 3'b101 GSI 21 (APIC output 5). The codes 3'b011, 3'b110 and 3'b111 route SCI nowhere.
- R6: The registered SCI level is ORed into the selected line together with any PIRQ traffic already on that line.
- R7: If the select changes while SCI is high, the old target drops and the new target rises in the cycle after the write.
- R8: Route status for PIRQ n: if bit 7 is set, the output reports line 16+n with the off flag low. If bit 7 is clear and the field is a valid PIC number, it reports that number with the off flag low. If bit 7 is clear and the field is 16 or more (only possible with a wider field), it reports the off flag high and line 0.
- R9: Write address n (0..7) loads the routing byte of PIRQ n and address 8 loads the SCI select. A write is visible on the outputs in the cycle after the write edge. Writes to addresses 9..15 change nothing.
- R10: Bits 6:4 of a routing byte have no effect on routing or on status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pirq_in | input | 8 | PIRQ levels, bit 0 = A |
| sci_in | input | 1 | ACPI SCI level |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address (0..7 routing, 8 SCI select) |
| cfg_wdata | input | 8 | Write data |
| pic_irq | output | 16 | Legacy PIC input levels IRQ 0..15 |
| apic_irq | output | 8 | APIC input levels GSI 16..23 |
| route_gsi | output | 40 | Per-PIRQ resolved line, 5 bits per PIRQ, PIRQ n at bits 5n+4:5n |
| route_off | output | 8 | Per-PIRQ flag: enabled legacy route points past the PIC |

## Verification
The bench targets cases where two sources land on one line. Two PIRQs share IRQ 5, and a PIRQ and the SCI share IRQ 10. A design that assigned the line instead of ORing it would drop one of the sources. The SCI is walked through every select code while held high. A design that latched the old target would leave a stale line up, and one that mis-decoded a reserved code would raise an output the SCI has no right to. Disabled routes are held high on the PIRQ side to show they leave the PIC silent yet keep their APIC line. Junk in bits 6:4, IRQ 0 and IRQ 15, writes to unmapped addresses that could alias onto a real register, and a second reset are checked through the route-status outputs.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;

   localparam int SCI_SEL_W  = 3;
   localparam int LINE_IDX_W = 5;

   typedef struct packed {
      logic                  hit;
      logic [LINE_IDX_W-1:0] line;
   } sci_tgt_t;

   // SCI target decode; line numbers span PIC lines then APIC lines
   function automatic sci_tgt_t sci_decode(input logic [SCI_SEL_W-1:0] sel);
      sci_tgt_t t;
      t = '0;
      case (sel)
         3'b000: t = '{hit: 1'b1, line: 5'd9};
         3'b001: t = '{hit: 1'b1, line: 5'd10};
         3'b010: t = '{hit: 1'b1, line: 5'd11};
         3'b100: t = '{hit: 1'b1, line: 5'd20};
         3'b101: t = '{hit: 1'b1, line: 5'd21};
         default: t = '0;
      endcase
      return t;
   endfunction

endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs
   import pirq_router_pkg::*;
#(
   parameter int NPIRQ   = 8,
   parameter int ADDR_W  = 4,
   parameter int DATA_W  = 8,
   parameter int FIELD_W = 4,
   parameter int DIS_BIT = 7,
   localparam int IDX_W  = $clog2(NPIRQ)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [NPIRQ-1:0][FIELD_W:0]   rt_q,
   output logic [SCI_SEL_W-1:0]          sel_q
);

   localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NPIRQ);

   logic hit_route, hit_sel;
   logic unused_wbits;

   assign hit_route    = wr_en && (wr_addr < SEL_ADDR);
   assign hit_sel      = wr_en && (wr_addr == SEL_ADDR);
   assign unused_wbits = ^wr_data[DIS_BIT-1:FIELD_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int n = 0; n < NPIRQ; n++) rt_q[n] <= {1'b1, {FIELD_W{1'b0}}};
         sel_q <= '0;
      end else begin
         if (hit_route)
            rt_q[wr_addr[IDX_W-1:0]] <= {wr_data[DIS_BIT], wr_data[FIELD_W-1:0]};
         if (hit_sel)
            sel_q <= wr_data[SCI_SEL_W-1:0];
      end
   end

endmodule

// File: rtl/pirq_pic_merge.sv
module pirq_pic_merge #(
   parameter int NPIRQ     = 8,
   parameter int PIC_LINES = 16,
   parameter int FIELD_W   = 4
) (
   input  logic [NPIRQ-1:0][FIELD_W:0] rt_q,
   input  logic [NPIRQ-1:0]            pirq_q,
   input  logic [PIC_LINES-1:0]        sci_pic,
   output logic [PIC_LINES-1:0]        pic_irq
);

   for (genvar k = 0; k < PIC_LINES; k++) begin : g_line
      logic acc;
      always_comb begin
         acc = sci_pic[k];
         for (int n = 0; n < NPIRQ; n++) begin
            if (!rt_q[n][FIELD_W] && pirq_q[n] &&
                (rt_q[n][FIELD_W-1:0] == FIELD_W'(k)))
               acc = 1'b1;
         end
      end
      assign pic_irq[k] = acc;
   end

endmodule

// File: rtl/pirq_route_status.sv
module pirq_route_status #(
   parameter int NPIRQ     = 8,
   parameter int PIC_LINES = 16,
   parameter int FIELD_W   = 4,
   parameter int GSI_W     = 5
) (
   input  logic [NPIRQ-1:0][FIELD_W:0] rt_q,
   output logic [NPIRQ*GSI_W-1:0]      route_gsi,
   output logic [NPIRQ-1:0]            route_off
);

   for (genvar n = 0; n < NPIRQ; n++) begin : g_lane
      logic oor;
      if ((1 << FIELD_W) > PIC_LINES) begin : g_wide
         assign oor = (int'(rt_q[n][FIELD_W-1:0]) >= PIC_LINES);
      end else begin : g_narrow
         assign oor = 1'b0;
      end

      always_comb begin
         route_off[n] = 1'b0;
         if (rt_q[n][FIELD_W]) begin
            route_gsi[n*GSI_W +: GSI_W] = GSI_W'(PIC_LINES + n);
         end else if (oor) begin
            route_gsi[n*GSI_W +: GSI_W] = '0;
            route_off[n]                = 1'b1;
         end else begin
            route_gsi[n*GSI_W +: GSI_W] = GSI_W'(rt_q[n][FIELD_W-1:0]);
         end
      end
   end

endmodule

// File: rtl/pirq_router.sv
module pirq_router
   import pirq_router_pkg::*;
#(
   parameter int NPIRQ     = 8,
   parameter int PIC_LINES = 16,
   parameter int FIELD_W   = 4,
   parameter int DIS_BIT   = 7,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   localparam int GSI_LINES = PIC_LINES + NPIRQ,
   localparam int GSI_W     = $clog2(GSI_LINES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPIRQ-1:0]         pirq_in,
   input  logic                     sci_in,
   input  logic                     cfg_wr_en,
   input  logic [ADDR_W-1:0]        cfg_addr,
   input  logic [DATA_W-1:0]        cfg_wdata,
   output logic [PIC_LINES-1:0]     pic_irq,
   output logic [NPIRQ-1:0]         apic_irq,
   output logic [NPIRQ*GSI_W-1:0]   route_gsi,
   output logic [NPIRQ-1:0]         route_off
);

   if (GSI_LINES <= 21 || PIC_LINES <= 11) begin : g_bad_lines
      $error("SCI targets need PIC lines above 11 and GSI lines above 21");
   end
   if (DIS_BIT <= FIELD_W || DIS_BIT >= DATA_W) begin : g_bad_bits
      $error("disable bit must sit above the field and inside the data word");
   end
   if ((1 << ADDR_W) <= NPIRQ) begin : g_bad_addr
      $error("address width too small for routing plus select registers");
   end
   if (GSI_W > LINE_IDX_W) begin : g_bad_gsi
      $error("line index too narrow");
   end

   logic [NPIRQ-1:0]            pirq_q;
   logic                        sci_q;
   logic [NPIRQ-1:0][FIELD_W:0] rt_q;
   logic [SCI_SEL_W-1:0]        sci_sel_q;
   sci_tgt_t                    sci_tgt;
   logic [GSI_LINES-1:0]        sci_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pirq_q <= '0;
         sci_q  <= 1'b0;
      end else begin
         pirq_q <= pirq_in;
         sci_q  <= sci_in;
      end
   end

   pirq_cfg_regs #(
      .NPIRQ(NPIRQ), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .FIELD_W(FIELD_W), .DIS_BIT(DIS_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
      .wr_data(cfg_wdata), .rt_q(rt_q), .sel_q(sci_sel_q)
   );

   assign sci_tgt = sci_decode(sci_sel_q);

   always_comb begin
      sci_hit = '0;
      for (int g = 0; g < GSI_LINES; g++)
         if (sci_q && sci_tgt.hit && (int'(sci_tgt.line) == g)) sci_hit[g] = 1'b1;
   end

   pirq_pic_merge #(
      .NPIRQ(NPIRQ), .PIC_LINES(PIC_LINES), .FIELD_W(FIELD_W)
   ) u_pic (
      .rt_q(rt_q), .pirq_q(pirq_q), .sci_pic(sci_hit[PIC_LINES-1:0]),
      .pic_irq(pic_irq)
   );

   assign apic_irq = pirq_q | sci_hit[GSI_LINES-1:PIC_LINES];

   pirq_route_status #(
      .NPIRQ(NPIRQ), .PIC_LINES(PIC_LINES), .FIELD_W(FIELD_W), .GSI_W(GSI_W)
   ) u_stat (
      .rt_q(rt_q), .route_gsi(route_gsi), .route_off(route_off)
   );

endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
   parameter int NPIRQ     = 8,
   parameter int PIC_LINES = 16,
   parameter int GSI_W     = 5
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NPIRQ-1:0]       pirq_in,
   input logic                   sci_in,
   input logic [2:0]             sci_sel,
   input logic [PIC_LINES-1:0]   pic_irq,
   input logic [NPIRQ-1:0]       apic_irq,
   input logic [NPIRQ*GSI_W-1:0] route_gsi,
   input logic [NPIRQ-1:0]       route_off
);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R2
   apic_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (($past(pirq_in) & ~apic_irq) == '0));

   // R5
   sci_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && (sci_sel inside {3'b011, 3'b110, 3'b111, 3'b000, 3'b001, 3'b010}))
         |-> (apic_irq == $past(pirq_in)));

   // R6
   sci_irq9_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(sci_in) && sci_sel == 3'b000) |-> pic_irq[9]);

   // R7
   sci_gsi20_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(sci_in) && sci_sel == 3'b100) |-> apic_irq[4]);

   for (genvar n = 0; n < NPIRQ; n++) begin : g_lane
      // R8
      status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !route_off[n] |-> ((int'(route_gsi[n*GSI_W +: GSI_W]) < PIC_LINES) ||
                            (int'(route_gsi[n*GSI_W +: GSI_W]) == PIC_LINES + n)));
      // R8
      status_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         route_off[n] |-> (route_gsi[n*GSI_W +: GSI_W] == '0));
   end

endmodule

bind pirq_router pirq_router_chk #(
   .NPIRQ(NPIRQ), .PIC_LINES(PIC_LINES), .GSI_W(GSI_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .sci_in(sci_in),
   .sci_sel(sci_sel_q), .pic_irq(pic_irq), .apic_irq(apic_irq),
   .route_gsi(route_gsi), .route_off(route_off)
);

// File: tb/sim_pirq_router.sv
`timescale 1ns/1ps
module sim_pirq_router;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pirq_in = '0;
   logic        sci_in = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [15:0] pic_irq;
   logic [7:0]  apic_irq;
   logic [39:0] route_gsi;
   logic [7:0]  route_off;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] sh_rt [8];
   logic [2:0] sh_sel;

   always #4 clk = ~clk;

   pirq_router u0 (
      .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .sci_in(sci_in),
      .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .pic_irq(pic_irq), .apic_irq(apic_irq),
      .route_gsi(route_gsi), .route_off(route_off)
   );

   // stimulus table: {pirq[7:0], sci}
   localparam logic [8:0] VEC [10] = '{
      9'b0000_0000_0, 9'b0000_0001_0, 9'b0000_0011_0, 9'b0000_0010_0,
      9'b0000_1000_0, 9'b0000_0100_1, 9'b0000_0000_1, 9'b0100_1000_0,
      9'b1111_1111_1, 9'b1011_0000_0
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] m_pic(input logic [7:0] p, input logic s);
      logic [15:0] r;
      r = '0;
      for (int n = 0; n < 8; n++)
         if (!sh_rt[n][7] && p[n]) r[sh_rt[n][3:0]] = 1'b1;
      if (s) begin
         case (sh_sel)
            3'b000: r[9]  = 1'b1;
            3'b001: r[10] = 1'b1;
            3'b010: r[11] = 1'b1;
            default: ;
         endcase
      end
      return r;
   endfunction

   function automatic logic [7:0] m_apic(input logic [7:0] p, input logic s);
      logic [7:0] r;
      r = p;
      if (s && sh_sel == 3'b100) r[4] = 1'b1;
      if (s && sh_sel == 3'b101) r[5] = 1'b1;
      return r;
   endfunction

   function automatic logic [4:0] m_gsi(input int n);
      return sh_rt[n][7] ? 5'(16 + n) : {1'b0, sh_rt[n][3:0]};
   endfunction

   task automatic shadow_reset();
      for (int n = 0; n < 8; n++) sh_rt[n] = 8'h80;
      sh_sel = 3'b000;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
      if (a < 4'd8) sh_rt[a[2:0]] = d;
      else if (a == 4'd8) sh_sel = d[2:0];
   endtask

   task automatic step(input logic [7:0] p, input logic s);
      @(negedge clk);
      pirq_in = p; sci_in = s;
      @(negedge clk);
   endtask

   task automatic chk_outputs(input string req);
      chk(req, 64'(pic_irq), 64'(m_pic(pirq_in, sci_in)));
      chk(req, 64'(apic_irq), 64'(m_apic(pirq_in, sci_in)));
   endtask

   task automatic chk_status(input string req);
      for (int n = 0; n < 8; n++)
         chk(req, 64'(route_gsi[n*5 +: 5]), 64'(m_gsi(n)));
      chk(req, 64'(route_off), 64'h0);
   endtask

   initial begin
      shadow_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pic", 64'(pic_irq), 64'h0);
      chk("R1 apic", 64'(apic_irq), 64'h0);
      chk_status("R1 status");
      // R1 default select is IRQ 9
      step(8'h00, 1'b1);
      chk("R1 sci default", 64'(pic_irq), 64'h0200);
      // R4 all disabled, R2 APIC follows
      step(8'hFF, 1'b0);
      chk("R4 pic silent", 64'(pic_irq), 64'h0);
      chk("R2 apic", 64'(apic_irq), 64'hFF);
      // R9 write timing
      wr(4'd0, 8'h05);
      chk("R9 write visible", 64'(route_gsi[4:0]), 64'd5);
      chk("R9 pic after write", 64'(pic_irq), 64'h0020);
      wr(4'd1, 8'h05); wr(4'd2, 8'h0A); wr(4'd3, 8'h83);
      wr(4'd4, 8'h77); wr(4'd5, 8'h09); wr(4'd6, 8'h8B); wr(4'd7, 8'h0F);
      wr(4'd8, 8'h01);
      // R8 R10 status after config
      chk_status("R8 R10 status");
      // R3 R4 R6 R10 table walk
      for (int i = 0; i < 10; i++) begin
         step(VEC[i][8:1], VEC[i][0]);
         chk_outputs("R3 R4 R6 table");
      end
      // R9 unmapped writes change nothing
      wr(4'd12, 8'h03);
      wr(4'd9, 8'h00);
      wr(4'd15, 8'h84);
      chk_status("R9 unmapped");
      step(8'h00, 1'b1);
      chk("R9 select kept", 64'(pic_irq), 64'h0400);
      // R7 retarget while SCI high, R5 encodings
      wr(4'd8, 8'h00);
      chk("R7 to irq9", 64'(pic_irq), 64'h0200);
      wr(4'd8, 8'h04);
      chk("R7 old released", 64'(pic_irq), 64'h0);
      chk("R7 gsi20", 64'(apic_irq), 64'h10);
      wr(4'd8, 8'h05);
      chk("R5 gsi21", 64'(apic_irq), 64'h20);
      wr(4'd8, 8'h02);
      chk("R5 irq11", 64'(pic_irq), 64'h0800);
      chk("R5 apic clear", 64'(apic_irq), 64'h0);
      for (int c = 0; c < 3; c++) begin
         logic [2:0] code;
         code = (c == 0) ? 3'b011 : (c == 1) ? 3'b110 : 3'b111;
         wr(4'd8, {5'b0, code});
         chk("R5 reserved pic", 64'(pic_irq), 64'h0);
         chk("R5 reserved apic", 64'(apic_irq), 64'h0);
      end
      // R6 SCI shares a line with PIRQ traffic
      wr(4'd8, 8'h01);
      step(8'h04, 1'b1);
      chk_outputs("R6 shared irq10");
      step(8'h04, 1'b0);
      chk("R6 pirq alone", 64'(pic_irq), 64'h0400);
      // R3 boundary lines
      wr(4'd7, 8'h00);
      wr(4'd0, 8'h0F);
      step(8'h81, 1'b0);
      chk("R3 irq0 irq15", 64'(pic_irq), 64'h8001);
      chk_outputs("R3 boundary");
      // R1 second reset
      @(negedge clk);
      rst_n = 1'b0;
      pirq_in = '0; sci_in = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      shadow_reset();
      @(negedge clk);
      chk_status("R1 re-reset status");
      chk("R1 re-reset pic", 64'(pic_irq), 64'h0);
      step(8'h00, 1'b1);
      chk("R1 re-reset select", 64'(pic_irq), 64'h0200);
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule